// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block works out the source operand value and the destination operand location for one instruction of a small 16-bit processor with sixteen registers. An instruction decoder hands it the source mode (two bits), the source register number, the destination mode (one bit), the destination register number, a byte-size flag and the address of the word that follows the opcode. A `start` pulse begins the work. The block then reads registers through a combinational read port and takes extension words from a valid/ready stream. It issues at most one memory read for the source, with one request outstanding at a time. It writes post-incremented registers back through a dedicated write port.

Register 0 serves as the program counter, which gives PC-relative addressing and immediates. Register 1 is the stack pointer, and its post-increment never steps by one. In the source field, register 2 and register 3 turn the mode bits into absolute addressing or into fixed constants. The source operand is resolved completely, including its write-back, before the destination address is formed. When both are finished, a one-cycle `done` strobe presents the source value, the destination address and a flag that marks a register destination.

Top module: `opnd_addr_seq`

## Requirements
- R1: Source mode 00 with a register other than 3 returns that register's value in `src_val` with no memory read and no extension word taken. Register 0 returns the address given on `pc_in`.
- R2: Source mode 01 with a register other than 2 or 3 takes one extension word and reads memory at that word plus the register value, modulo 2^16. `src_val` is the data that comes back.
- R3: Source mode 10 reads memory at the register value and writes nothing back. Source mode 11 reads the same address and writes back the register plus 1 for a byte access (`byte_op`=1) or plus 2 for a word access. The write-back strobe rises in the cycle in which the read request is accepted.
- R4: A mode 11 source on register 1 writes back the register plus 2, even for a byte access.
- R5: With register 0, the program counter starts at `pc_in` and moves forward 2 for every extension word taken. Indexed mode adds the extension word to the address of that word. Mode 10 reads at the current program counter. Mode 11 reads there and writes back the program counter plus 2, which gives an immediate.
- R6: With register 2 in the source field: mode 00 is a normal register read. Mode 01 uses the extension word directly as the read address. Mode 10 yields the constant 4 and mode 11 yields the constant 8, with no memory read.
- R7: With register 3 in the source field, modes 00, 01, 10 and 11 yield 0x0000, 0x0001, 0x0002 and 0xFFFF. No memory read is made and no extension word is taken.
- R8: Destination mode 0 sets `dst_is_reg`=1. Destination mode 1 clears it and sets `dst_addr` to an extension word plus the destination register (for register 0, the address of that word). That word is taken after any source extension word.
- R9: When the source is mode 11 on the same register as an indexed destination, the destination address uses the incremented register value.
- R10: `done` is high for one cycle only. For a register source and a register destination it is seen three cycles after the edge that samples `start`. No more than one memory read is accepted per instruction. A request that is not accepted stays valid with a stable address.
- R11: After reset, `done`, `mem_req_valid`, `ext_ready` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving operands; sampled while idle |
| src_mode | input | 2 | Source addressing mode |
| src_reg | input | 4 | Source register number |
| dst_mode | input | 1 | Destination mode: 0 register, 1 indexed |
| dst_reg | input | 4 | Destination register number |
| byte_op | input | 1 | Byte-sized operand access |
| pc_in | input | 16 | Address of the word following the opcode |
| rf_raddr | output | 4 | Register file read address |
| rf_rdata | input | 16 | Register file read data (combinational) |
| ext_valid | input | 1 | Extension word available |
| ext_word | input | 16 | Extension word |
| ext_ready | output | 1 | Extension word taken when both valid and ready |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 16 | Memory read address |
| mem_req_byte | output | 1 | Memory read is byte-sized |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data |
| wb_en | output | 1 | Register write-back strobe |
| wb_reg | output | 4 | Write-back register number |
| wb_data | output | 16 | Write-back value |
| done | output | 1 | Operands resolved (one-cycle strobe) |
| src_val | output | 16 | Resolved source value |
| dst_addr | output | 16 | Destination memory address |
| dst_is_reg | output | 1 | Destination is the register itself |

## Verification
The source value, destination address and register flag are registered and are valid in the cycle in which `done` is high. The bench waits on falling edges for that strobe and samples them there. A write-back lands in the bench register model at the edge on which the read request is accepted, so register contents are compared after `done`. For a register-to-register instruction, the bench counts falling edges after the edge that samples `start` and expects `done` on the third. The bench also counts memory reads and extension words taken over the whole instruction, so constants, register-direct sources and operand ordering are checked by those counts as well as by the values.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
   localparam int unsigned PC_NUM = 0;
   localparam int unsigned SP_NUM = 1;
   localparam int unsigned SR_NUM = 2;
   localparam int unsigned CG_NUM = 3;

   typedef enum logic [2:0] {
      SK_REG, SK_CONST, SK_INDEX, SK_ABS, SK_INDIR, SK_POSTINC
   } src_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SRC, ST_SREQ, ST_SRSP, ST_DST, ST_DONE
   } seq_state_e;
endpackage

// File: rtl/opnd_src_decode.sv
module opnd_src_decode
   import opnd_pkg::*;
#(
   parameter int unsigned DW = 16,
   parameter int unsigned RW = 4
) (
   input  logic [1:0]    mode,
   input  logic [RW-1:0] rnum,
   output src_kind_e     kind,
   output logic [DW-1:0] cval
);
   always_comb begin
      kind = SK_REG;
      cval = '0;
      if (rnum == RW'(CG_NUM)) begin
         kind = SK_CONST;
         case (mode)
            2'b00:   cval = '0;
            2'b01:   cval = DW'(1);
            2'b10:   cval = DW'(2);
            default: cval = '1;
         endcase
      end else if (rnum == RW'(SR_NUM) && mode != 2'b00) begin
         case (mode)
            2'b01:   kind = SK_ABS;
            2'b10: begin kind = SK_CONST; cval = DW'(4); end
            default: begin kind = SK_CONST; cval = DW'(8); end
         endcase
      end else begin
         case (mode)
            2'b00:   kind = SK_REG;
            2'b01:   kind = SK_INDEX;
            2'b10:   kind = SK_INDIR;
            default: kind = SK_POSTINC;
         endcase
      end
   end
endmodule

// File: rtl/opnd_ea_add.sv
module opnd_ea_add #(
   parameter int unsigned DW = 16
) (
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] offs,
   output logic [DW-1:0] sum
);
   // wraps across the address space by width truncation
   assign sum = base + offs;
endmodule

// File: rtl/opnd_postinc.sv
module opnd_postinc
   import opnd_pkg::*;
#(
   parameter int unsigned DW            = 16,
   parameter int unsigned RW            = 4,
   parameter bit          SP_ALWAYS_WORD = 1'b1
) (
   input  logic [RW-1:0] rnum,
   input  logic          byte_op,
   input  logic [DW-1:0] base,
   output logic [DW-1:0] next
);
   logic single;

   generate
      if (SP_ALWAYS_WORD) begin : g_sp_word
         assign single = byte_op && rnum != RW'(PC_NUM) && rnum != RW'(SP_NUM);
      end else begin : g_sp_plain
         assign single = byte_op && rnum != RW'(PC_NUM);
      end
   endgenerate

   assign next = base + (single ? DW'(1) : DW'(2));
endmodule

// File: rtl/opnd_addr_seq.sv
module opnd_addr_seq
   import opnd_pkg::*;
#(
   parameter int unsigned DW   = 16,
   parameter int unsigned NREG = 16,
   localparam int unsigned RW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    src_mode,
   input  logic [RW-1:0] src_reg,
   input  logic          dst_mode,
   input  logic [RW-1:0] dst_reg,
   input  logic          byte_op,
   input  logic [DW-1:0] pc_in,
   output logic [RW-1:0] rf_raddr,
   input  logic [DW-1:0] rf_rdata,
   input  logic          ext_valid,
   input  logic [DW-1:0] ext_word,
   output logic          ext_ready,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [DW-1:0] mem_req_addr,
   output logic          mem_req_byte,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data,
   output logic          wb_en,
   output logic [RW-1:0] wb_reg,
   output logic [DW-1:0] wb_data,
   output logic          done,
   output logic [DW-1:0] src_val,
   output logic [DW-1:0] dst_addr,
   output logic          dst_is_reg
);
   localparam logic [DW-1:0] WSTEP = DW'(2);

   generate
      if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
         $error("opnd_addr_seq: DW must be a multiple of 8");
      end
      if (NREG < 4 || (1 << RW) != NREG) begin : g_bad_nreg
         $error("opnd_addr_seq: NREG must be a power of two, at least 4");
      end
   endgenerate

   seq_state_e    state_q;
   logic [1:0]    smode_q;
   logic [RW-1:0] sreg_q, dreg_q;
   logic          dmode_q, byte_q, pinc_q, dreg_flag_q;
   logic [DW-1:0] pc_q, addr_q, inc_q, sval_q, daddr_q;

   src_kind_e     kind;
   logic [DW-1:0] cval, reg_val, dst_base, ea_base, ea_sum, inc_val;

   opnd_src_decode #(.DW(DW), .RW(RW)) u_dec (
      .mode(smode_q), .rnum(sreg_q), .kind(kind), .cval(cval));

   // register read: program counter is tracked locally
   assign rf_raddr = (state_q == ST_DST) ? dreg_q : sreg_q;
   assign reg_val  = (rf_raddr == RW'(PC_NUM)) ? pc_q : rf_rdata;

   // forward a post-incremented value to a same-register destination
   assign dst_base = (pinc_q && dreg_q == sreg_q && dreg_q != RW'(PC_NUM)) ? inc_q : reg_val;
   assign ea_base  = (state_q == ST_DST) ? dst_base :
                     (kind == SK_ABS)    ? '0       : reg_val;

   opnd_ea_add #(.DW(DW)) u_add (.base(ea_base), .offs(ext_word), .sum(ea_sum));

   opnd_postinc #(.DW(DW), .RW(RW), .SP_ALWAYS_WORD(1'b1)) u_inc (
      .rnum(sreg_q), .byte_op(byte_q), .base(reg_val), .next(inc_val));

   assign ext_ready     = (state_q == ST_SRC && (kind == SK_INDEX || kind == SK_ABS)) ||
                          (state_q == ST_DST && dmode_q);
   assign mem_req_valid = (state_q == ST_SREQ);
   assign mem_req_addr  = addr_q;
   assign mem_req_byte  = byte_q;
   assign wb_en         = (state_q == ST_SREQ) && mem_req_ready && pinc_q;
   assign wb_reg        = sreg_q;
   assign wb_data       = inc_q;
   assign done          = (state_q == ST_DONE);
   assign src_val       = sval_q;
   assign dst_addr      = daddr_q;
   assign dst_is_reg    = dreg_flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         smode_q     <= '0;
         sreg_q      <= '0;
         dreg_q      <= '0;
         dmode_q     <= 1'b0;
         byte_q      <= 1'b0;
         pinc_q      <= 1'b0;
         dreg_flag_q <= 1'b0;
         pc_q        <= '0;
         addr_q      <= '0;
         inc_q       <= '0;
         sval_q      <= '0;
         daddr_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               smode_q <= src_mode;
               sreg_q  <= src_reg;
               dmode_q <= dst_mode;
               dreg_q  <= dst_reg;
               byte_q  <= byte_op;
               pc_q    <= pc_in;
               pinc_q  <= 1'b0;
               state_q <= ST_SRC;
            end
            ST_SRC: begin
               case (kind)
                  SK_REG: begin
                     sval_q  <= reg_val;
                     state_q <= ST_DST;
                  end
                  SK_CONST: begin
                     sval_q  <= cval;
                     state_q <= ST_DST;
                  end
                  SK_INDEX, SK_ABS: if (ext_valid) begin
                     addr_q  <= ea_sum;
                     pc_q    <= pc_q + WSTEP;
                     state_q <= ST_SREQ;
                  end
                  SK_INDIR: begin
                     addr_q  <= reg_val;
                     state_q <= ST_SREQ;
                  end
                  default: begin
                     addr_q  <= reg_val;
                     inc_q   <= inc_val;
                     pinc_q  <= 1'b1;
                     state_q <= ST_SREQ;
                  end
               endcase
            end
            ST_SREQ: if (mem_req_ready) begin
               if (pinc_q && sreg_q == RW'(PC_NUM)) pc_q <= inc_q;
               state_q <= ST_SRSP;
            end
            ST_SRSP: if (mem_rsp_valid) begin
               sval_q  <= mem_rsp_data;
               state_q <= ST_DST;
            end
            ST_DST: begin
               if (!dmode_q) begin
                  dreg_flag_q <= 1'b1;
                  daddr_q     <= '0;
                  state_q     <= ST_DONE;
               end else if (ext_valid) begin
                  dreg_flag_q <= 1'b0;
                  daddr_q     <= ea_sum;
                  pc_q        <= pc_q + WSTEP;
                  state_q     <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/opnd_addr_seq_chk.sv
module opnd_addr_seq_chk
   import opnd_pkg::*;
#(
   parameter int unsigned DW = 16,
   parameter int unsigned RW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          done,
   input logic          mem_req_valid,
   input logic          mem_req_ready,
   input logic [DW-1:0] mem_req_addr,
   input logic          wb_en,
   input logic [RW-1:0] wb_reg,
   input logic [DW-1:0] wb_data,
   input logic [DW-1:0] rf_rdata
);
   logic [1:0] rd_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rd_cnt <= '0;
      else if (done)                           rd_cnt <= '0;
      else if (mem_req_valid && mem_req_ready && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
   end

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   p_one_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rd_cnt <= 2'd1));

   p_wb_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (mem_req_valid && mem_req_ready));

   p_sp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && wb_reg == RW'(SP_NUM)) |-> (wb_data == rf_rdata + DW'(2)));
endmodule

bind opnd_addr_seq opnd_addr_seq_chk #(.DW(DW), .RW(RW)) u_chk (
   .clk(clk), .rst_n(rst_n), .done(done),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr), .wb_en(wb_en), .wb_reg(wb_reg),
   .wb_data(wb_data), .rf_rdata(rf_rdata));

// File: tb/opnd_addr_seq_tb.sv
`timescale 1ns/1ps
module opnd_addr_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  src_mode = '0;
   logic [3:0]  src_reg = '0;
   logic        dst_mode = 1'b0;
   logic [3:0]  dst_reg = '0;
   logic        byte_op = 1'b0;
   logic [15:0] pc_in = '0;
   logic [3:0]  rf_raddr;
   logic [15:0] rf_rdata;
   logic        ext_valid;
   logic [15:0] ext_word;
   logic        ext_ready;
   logic        mem_req_valid, mem_req_ready, mem_req_byte;
   logic [15:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [15:0] mem_rsp_data = '0;
   logic        wb_en, done, dst_is_reg;
   logic [3:0]  wb_reg;
   logic [15:0] wb_data, src_val, dst_addr;

   logic [15:0] rf [16];
   logic [15:0] ext_words [32];
   logic [4:0]  ext_idx = '0;
   int          rd_total = 0;
   logic [15:0] last_addr = '0;
   logic        slow_mem = 1'b0;
   logic        stalled = 1'b0;
   int          checks = 0;
   int          failures = 0;
   bit          finished = 1'b0;

   // per-run results
   int          lat;
   int          ext_used;
   int          rd_used;
   logic [15:0] got_src, got_dst;
   logic        got_isreg;

   always #2.5 clk = ~clk;

   opnd_addr_seq u_dut (.*);

   function automatic logic [15:0] memfn(input logic [15:0] a, input logic b);
      logic [15:0] w;
      w = a ^ 16'h5A3C;
      return b ? {8'h00, w[7:0]} : w;
   endfunction

   assign rf_rdata      = rf[rf_raddr];
   assign ext_valid     = 1'b1;
   assign ext_word      = ext_words[ext_idx];
   assign mem_req_ready = !slow_mem || stalled;

   always @(posedge clk) begin
      stalled <= mem_req_valid && !mem_req_ready;
      if (ext_valid && ext_ready) ext_idx <= ext_idx + 5'd1;
      if (wb_en) rf[wb_reg] <= wb_data;
      if (mem_req_valid && mem_req_ready) begin
         rd_total      <= rd_total + 1;
         last_addr     <= mem_req_addr;
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= memfn(mem_req_addr, mem_req_byte);
      end else begin
         mem_rsp_valid <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [1:0] sm, input logic [3:0] sr, input logic dm,
                      input logic [3:0] dr, input logic bo, input logic [15:0] pc,
                      input logic [15:0] e0, input logic [15:0] e1);
      int e_base, r_base;
      @(negedge clk);
      ext_words[ext_idx]        = e0;
      ext_words[ext_idx + 5'd1] = e1;
      e_base   = int'(ext_idx);
      r_base   = rd_total;
      src_mode = sm; src_reg = sr; dst_mode = dm; dst_reg = dr;
      byte_op  = bo; pc_in = pc; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 60) begin
         @(negedge clk);
         lat++;
      end
      if (!done) chk(1'b0, "R10 timeout", 16'(lat), 16'd0);
      got_src   = src_val;
      got_dst   = dst_addr;
      got_isreg = dst_is_reg;
      @(negedge clk);
      ext_used = (int'(ext_idx) - e_base + 32) % 32;
      rd_used  = rd_total - r_base;
   endtask

   task automatic t_reset;
      chk(!done && !mem_req_valid && !ext_ready && !wb_en, "R11 reset outputs",
          {12'h0, done, mem_req_valid, ext_ready, wb_en}, 16'h0);
   endtask

   task automatic t_reg_direct;
      rf[5] = 16'h1357;
      run(2'b00, 4'd5, 1'b0, 4'd6, 1'b0, 16'h0100, 16'h0, 16'h0);
      chk(got_src == 16'h1357, "R1 register direct value", got_src, 16'h1357);
      chk(rd_used == 0 && ext_used == 0, "R1 no read, no ext", 16'(rd_used + ext_used), 16'h0);
      chk(got_isreg == 1'b1, "R8 register destination", {15'h0, got_isreg}, 16'h1);
      chk(lat == 3, "R10 reg-reg latency", 16'(lat), 16'd3);
      run(2'b00, 4'd0, 1'b0, 4'd6, 1'b0, 16'h0420, 16'h0, 16'h0);
      chk(got_src == 16'h0420, "R1 register 0 gives pc", got_src, 16'h0420);
   endtask

   task automatic t_indexed;
      rf[5] = 16'hFFF8;
      run(2'b01, 4'd5, 1'b0, 4'd6, 1'b0, 16'h0100, 16'h0010, 16'h0);
      chk(last_addr == 16'h0008, "R2 indexed wraps", last_addr, 16'h0008);
      chk(got_src == memfn(16'h0008, 1'b0), "R2 indexed data", got_src, memfn(16'h0008, 1'b0));
      chk(ext_used == 1 && rd_used == 1, "R2 one ext one read", 16'(ext_used * 16 + rd_used), 16'h11);
   endtask

   task automatic t_indirect;
      rf[7] = 16'h2244;
      run(2'b10, 4'd7, 1'b0, 4'd6, 1'b1, 16'h0100, 16'h0, 16'h0);
      chk(last_addr == 16'h2244 && got_src == memfn(16'h2244, 1'b1), "R3 indirect byte read",
          got_src, memfn(16'h2244, 1'b1));
      chk(rf[7] == 16'h2244, "R3 indirect no write-back", rf[7], 16'h2244);
      run(2'b11, 4'd7, 1'b0, 4'd6, 1'b1, 16'h0100, 16'h0, 16'h0);
      chk(last_addr == 16'h2244, "R3 postinc address", last_addr, 16'h2244);
      chk(rf[7] == 16'h2245, "R3 byte postinc +1", rf[7], 16'h2245);
      slow_mem = 1'b1;
      run(2'b11, 4'd7, 1'b0, 4'd6, 1'b0, 16'h0100, 16'h0, 16'h0);
      slow_mem = 1'b0;
      chk(rf[7] == 16'h2247 && rd_used == 1, "R3 word postinc +2 slow memory", rf[7], 16'h2247);
      chk(got_src == memfn(16'h2245, 1'b0), "R10 held request data", got_src, memfn(16'h2245, 1'b0));
   endtask

   task automatic t_sp;
      rf[1] = 16'h0F00;
      run(2'b11, 4'd1, 1'b0, 4'd6, 1'b1, 16'h0100, 16'h0, 16'h0);
      chk(rf[1] == 16'h0F02, "R4 stack byte postinc +2", rf[1], 16'h0F02);
   endtask

   task automatic t_pc;
      rf[0] = 16'h0200;
      run(2'b01, 4'd0, 1'b0, 4'd6, 1'b0, 16'h0200, 16'h0040, 16'h0);
      chk(last_addr == 16'h0240, "R5 pc-relative", last_addr, 16'h0240);
      run(2'b10, 4'd0, 1'b0, 4'd6, 1'b0, 16'h0200, 16'h0, 16'h0);
      chk(last_addr == 16'h0200 && rf[0] == 16'h0200, "R5 pc indirect", last_addr, 16'h0200);
      run(2'b11, 4'd0, 1'b1, 4'd0, 1'b0, 16'h0200, 16'h0006, 16'h0);
      chk(last_addr == 16'h0200 && got_src == memfn(16'h0200, 1'b0), "R5 immediate read",
          got_src, memfn(16'h0200, 1'b0));
      chk(rf[0] == 16'h0202, "R5 immediate advances pc", rf[0], 16'h0202);
      chk(got_dst == 16'h0208 && !got_isreg, "R8 pc-relative destination", got_dst, 16'h0208);
      chk(ext_used == 1, "R5 immediate uses no ext word", 16'(ext_used), 16'd1);
   endtask

   task automatic t_sr;
      rf[2] = 16'h0F0F;
      run(2'b00, 4'd2, 1'b0, 4'd6, 1'b0, 16'h0100, 16'h0, 16'h0);
      chk(got_src == 16'h0F0F, "R6 r2 normal", got_src, 16'h0F0F);
      run(2'b01, 4'd2, 1'b0, 4'd6, 1'b0, 16'h0100, 16'h1234, 16'h0);
      chk(last_addr == 16'h1234 && ext_used == 1, "R6 absolute", last_addr, 16'h1234);
      run(2'b10, 4'd2, 1'b0, 4'd6, 1'b0, 16'h0100, 16'h0, 16'h0);
      chk(got_src == 16'd4 && rd_used == 0, "R6 constant 4", got_src, 16'd4);
      run(2'b11, 4'd2, 1'b0, 4'd6, 1'b0, 16'h0100, 16'h0, 16'h0);
      chk(got_src == 16'd8 && rd_used == 0, "R6 constant 8", got_src, 16'd8);
   endtask

   task automatic t_cg;
      logic [15:0] exp [4];
      exp[0] = 16'h0000; exp[1] = 16'h0001; exp[2] = 16'h0002; exp[3] = 16'hFFFF;
      for (int m = 0; m < 4; m++) begin
         run(2'(m), 4'd3, 1'b0, 4'd6, 1'b0, 16'h0100, 16'hBEEF, 16'h0);
         chk(got_src == exp[m], "R7 r3 constant", got_src, exp[m]);
         chk(rd_used == 0 && ext_used == 0, "R7 no read no ext", 16'(rd_used + ext_used), 16'h0);
      end
   endtask

   task automatic t_both_indexed;
      rf[4] = 16'h1000; rf[9] = 16'h3000;
      run(2'b01, 4'd4, 1'b1, 4'd9, 1'b0, 16'h0100, 16'h0100, 16'h0020);
      chk(last_addr == 16'h1100, "R8 source takes first ext", last_addr, 16'h1100);
      chk(got_dst == 16'h3020 && !got_isreg, "R8 destination takes second ext", got_dst, 16'h3020);
      chk(ext_used == 2, "R8 two ext words", 16'(ext_used), 16'd2);
   endtask

   task automatic t_same_reg;
      rf[6] = 16'h0300;
      run(2'b11, 4'd6, 1'b1, 4'd6, 1'b0, 16'h0100, 16'hFFFE, 16'h0);
      chk(last_addr == 16'h0300, "R9 source address", last_addr, 16'h0300);
      chk(got_dst == 16'h0300, "R9 destination uses incremented reg", got_dst, 16'h0300);
      chk(rf[6] == 16'h0302, "R9 write-back", rf[6], 16'h0302);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) rf[i] = 16'(i * 16'h0111);
      for (int i = 0; i < 32; i++) ext_words[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reg_direct();
      t_indexed();
      t_indirect();
      t_sp();
      t_pc();
      t_sr();
      t_cg();
      t_both_indexed();
      t_same_reg();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule